// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the error bookkeeping of a CAN node and decides how the node may use the bus. It holds a transmit error count and a receive error count. From these counts it derives one of three node states: ACTIVE (full participation, active error flags), PASSIVE (still on the bus, but errors are signalled with passive flags and a pause follows each own transmission) and BUSOFF (no influence on the bus at all). The bit-level protocol engine feeds it single-cycle event strobes, plus the sampled bus level with a bit-time strobe. The block answers with the state, both counts, sticky status flags with a masked interrupt, an error-frame request with its flavour, a transmit permit, and a gated transmit bit.

The state register moves on the same clock edge as the counters. The transitions are: ACTIVE to PASSIVE when either count rises above 127; PASSIVE back to ACTIVE once both counts are 127 or less; ACTIVE or PASSIVE to BUSOFF when the transmit count rises above 255; BUSOFF to ACTIVE after 128 completed runs of 11 recessive bit times, at which point both counts are cleared. A separate small unit checks the acknowledge slot, and another times the transmit pause in PASSIVE.

Top module: `can_fault_guard`

## Requirements
- R1: A transmit error strobe, or an acknowledge error, adds 8 to the transmit count. A transmit success strobe subtracts 1 from it, never going below 0. When both arrive in one cycle, the error wins.
- R2: A receive error strobe adds 1 to the receive count, which saturates at 511 (CNT_W=9). A receive success strobe subtracts 1, never going below 0.
- R3: After reset, state_o is ACTIVE and err_cnt_o is 0. status_o is 0, err_req_o is 0, tx_permit_o is 1, and tx_bit_o follows tx_bit_i. The state encoding is ACTIVE=0, PASSIVE=1, BUSOFF=2. err_cnt_o carries the receive count in its upper CNT_W bits and the transmit count in its lower CNT_W bits.
- R4: ACTIVE becomes PASSIVE on the edge where either count exceeds 127. PASSIVE becomes ACTIVE on the edge where both counts are at most 127.
- R5: The node enters BUSOFF on the edge where the transmit count exceeds 255. While in BUSOFF, all error and success strobes leave both counts unchanged.
- R6: In BUSOFF, tx_bit_o is 1 (recessive) whatever tx_bit_i is, err_req_o stays 0 and tx_permit_o is 0.
- R7: In BUSOFF, bit ticks with bus_bit_i=1 (recessive) extend a run. A dominant tick restarts the run. The tick that completes the 128th run of 11 moves the node to ACTIVE on that edge and clears both counts.
- R8: One cycle after a transmit, receive or acknowledge error outside BUSOFF, err_req_o is high for one cycle. err_passive_o is 1 exactly when state_o is PASSIVE.
- R9: A bit tick with ack_slot_i=1 and a recessive bus bit is an acknowledge error: it sets status_o[3] and requests an error frame (R8). A dominant acknowledge slot does nothing.
- R10: A transmit success or transmit error while in PASSIVE drops tx_permit_o. tx_permit_o rises again after 8 recessive bit ticks; dominant ticks do not count.
- R11: status_o[0], [1] and [2] are set on entry to ACTIVE, PASSIVE and BUSOFF. All flags stay set until a stat_clr_i strobe; a new set in the same cycle wins.
- R12: irq_o is high whenever a status flag and the matching irq_mask_i bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Transmit success strobe |
| rx_ok_i | input | 1 | Receive success strobe |
| bit_tick_i | input | 1 | One pulse per bit time |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| ack_slot_i | input | 1 | Marks the tick of the own acknowledge slot |
| tx_bit_i | input | 1 | Transmit bit from the protocol engine |
| stat_clr_i | input | 1 | Read-clear strobe for status flags |
| irq_mask_i | input | 4 | Interrupt enable per status flag |
| state_o | output | 2 | Node state |
| err_cnt_o | output | 2*CNT_W | {receive count, transmit count} |
| status_o | output | 4 | Sticky flags: [0] active, [1] passive, [2] bus off, [3] ack error |
| irq_o | output | 1 | Masked interrupt |
| err_req_o | output | 1 | Error-frame request pulse |
| err_passive_o | output | 1 | Error-frame flavour, 1 = passive |
| tx_permit_o | output | 1 | Transmission may start |
| tx_bit_o | output | 1 | Transmit bit to the bus |

## Verification
Counts, state, sticky flags, the error-frame request and the transmit permit are registered. Each is due on the first rising edge after the strobe or tick that causes it, with no further latency. irq_o and tx_bit_o are combinational from registered state and the current inputs. The bench changes inputs only on falling edges, holds each strobe for one cycle, and reads results on the next falling edge, which is half a cycle after the edge that produced them. The one-cycle request pulse is checked high there, and low one cycle later.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    localparam int FLAG_N  = 4;
    localparam int FLG_ACT = 0;
    localparam int FLG_PAS = 1;
    localparam int FLG_BOF = 2;
    localparam int FLG_ACK = 3;
endpackage

// File: rtl/fc_err_counters.sv
`timescale 1ns/1ps
module fc_err_counters #(
    parameter int CNT_W   = 9,
    parameter int TX_STEP = 8,
    parameter int RX_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             clr_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    output logic [CNT_W-1:0] tec_q,
    output logic [CNT_W-1:0] rec_q,
    output logic [CNT_W-1:0] tec_d,
    output logic [CNT_W-1:0] rec_d
);
    localparam logic [CNT_W:0] TINC = (CNT_W+1)'(TX_STEP);
    localparam logic [CNT_W:0] RINC = (CNT_W+1)'(RX_STEP);

    logic [CNT_W:0] tsum, rsum;

    always_comb begin
        tsum  = {1'b0, tec_q} + TINC;
        rsum  = {1'b0, rec_q} + RINC;
        tec_d = tec_q;
        rec_d = rec_q;
        if (clr_i) begin
            tec_d = '0;
            rec_d = '0;
        end else if (!hold_i) begin
            if (tx_err_i)
                tec_d = tsum[CNT_W] ? '1 : tsum[CNT_W-1:0];
            else if (tx_ok_i && tec_q != '0)
                tec_d = tec_q - 1'b1;
            if (rx_err_i)
                rec_d = rsum[CNT_W] ? '1 : rsum[CNT_W-1:0];
            else if (rx_ok_i && rec_q != '0)
                rec_d = rec_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tec_q <= '0;
            rec_q <= '0;
        end else begin
            tec_q <= tec_d;
            rec_q <= rec_d;
        end
    end
endmodule

// File: rtl/fc_busoff_recovery.sv
`timescale 1ns/1ps
module fc_busoff_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_tick_i,
    input  logic bus_bit_i,
    output logic done_o
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int OW = $clog2(RUN_COUNT + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [OW-1:0] OCC_LAST = OW'(RUN_COUNT - 1);

    logic [RW-1:0] run_q;
    logic [OW-1:0] occ_q;
    logic          rec_tick, run_end;

    assign rec_tick = en_i && bit_tick_i && bus_bit_i;
    assign run_end  = rec_tick && (run_q == RUN_LAST);
    assign done_o   = run_end && (occ_q == OCC_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (!en_i) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (bit_tick_i) begin
            if (!bus_bit_i) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                occ_q <= occ_q + 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_suspend_timer.sv
`timescale 1ns/1ps
module fc_suspend_timer #(
    parameter int SUSPEND_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic load_i,
    input  logic bit_tick_i,
    input  logic bus_bit_i,
    output logic permit_o
);
    localparam int SW = $clog2(SUSPEND_BITS + 1);
    localparam logic [SW-1:0] START = SW'(SUSPEND_BITS);

    logic [SW-1:0] left_q;

    assign permit_o = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (flush_i)
            left_q <= '0;
        else if (load_i)
            left_q <= START;
        else if (bit_tick_i && bus_bit_i && left_q != '0)
            left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/can_fault_guard.sv
`timescale 1ns/1ps
module can_fault_guard #(
    parameter int CNT_W        = 9,
    parameter int PASSIVE_LIM  = 127,
    parameter int BUSOFF_LIM   = 255,
    parameter int TX_STEP      = 8,
    parameter int RX_STEP      = 1,
    parameter int RUN_LEN      = 11,
    parameter int RUN_COUNT    = 128,
    parameter int SUSPEND_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_err_i,
    input  logic                 rx_err_i,
    input  logic                 tx_ok_i,
    input  logic                 rx_ok_i,
    input  logic                 bit_tick_i,
    input  logic                 bus_bit_i,
    input  logic                 ack_slot_i,
    input  logic                 tx_bit_i,
    input  logic                 stat_clr_i,
    input  logic [3:0]           irq_mask_i,
    output logic [1:0]           state_o,
    output logic [2*CNT_W-1:0]   err_cnt_o,
    output logic [3:0]           status_o,
    output logic                 irq_o,
    output logic                 err_req_o,
    output logic                 err_passive_o,
    output logic                 tx_permit_o,
    output logic                 tx_bit_o
);
    import fc_pkg::*;

    localparam logic [CNT_W-1:0] PAS_LIM = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] BOF_LIM = CNT_W'(BUSOFF_LIM);

    fc_state_e             state_q, state_d;
    logic [CNT_W-1:0]      tec_q, rec_q, tec_d, rec_d;
    logic [FLAG_N-1:0]     flags_q, flag_set;
    logic                  busoff, ack_err, tx_err_ev, recover, permit, req_q;

    assign busoff    = (state_q == FC_BUSOFF);
    assign ack_err   = ack_slot_i && bit_tick_i && bus_bit_i && !busoff;
    assign tx_err_ev = tx_err_i || ack_err;

    fc_err_counters #(
        .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold_i(busoff), .clr_i(recover),
        .tx_err_i(tx_err_ev), .tx_ok_i(tx_ok_i),
        .rx_err_i(rx_err_i), .rx_ok_i(rx_ok_i),
        .tec_q(tec_q), .rec_q(rec_q), .tec_d(tec_d), .rec_d(rec_d)
    );

    fc_busoff_recovery #(
        .RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)
    ) u_rcv (
        .clk(clk), .rst_n(rst_n), .en_i(busoff),
        .bit_tick_i(bit_tick_i), .bus_bit_i(bus_bit_i), .done_o(recover)
    );

    fc_suspend_timer #(
        .SUSPEND_BITS(SUSPEND_BITS)
    ) u_sus (
        .clk(clk), .rst_n(rst_n), .flush_i(busoff),
        .load_i((state_q == FC_PASSIVE) && (tx_ok_i || tx_err_ev)),
        .bit_tick_i(bit_tick_i), .bus_bit_i(bus_bit_i), .permit_o(permit)
    );

    // next state from the counter values being written on this edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (tec_d > BOF_LIM)                         state_d = FC_BUSOFF;
                else if (tec_d > PAS_LIM || rec_d > PAS_LIM) state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (tec_d > BOF_LIM)                           state_d = FC_BUSOFF;
                else if (tec_d <= PAS_LIM && rec_d <= PAS_LIM) state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recover) state_d = FC_ACTIVE;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_ACT] = (state_d == FC_ACTIVE)  && (state_q != FC_ACTIVE);
        flag_set[FLG_PAS] = (state_d == FC_PASSIVE) && (state_q != FC_PASSIVE);
        flag_set[FLG_BOF] = (state_d == FC_BUSOFF)  && (state_q != FC_BUSOFF);
        flag_set[FLG_ACK] = ack_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
            flags_q <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            flags_q <= (stat_clr_i ? '0 : flags_q) | flag_set;
            req_q   <= (tx_err_i || rx_err_i || ack_err) && !busoff;
        end
    end

    always_comb begin
        state_o       = state_q;
        err_cnt_o     = {rec_q, tec_q};
        status_o      = flags_q;
        irq_o         = |(flags_q & irq_mask_i);
        err_req_o     = req_q && !busoff;
        err_passive_o = (state_q == FC_PASSIVE);
        tx_permit_o   = permit && !busoff;
        tx_bit_o      = busoff ? 1'b1 : tx_bit_i;
    end
endmodule

// File: rtl/fc_guard_chk.sv
`timescale 1ns/1ps
module fc_guard_chk #(
    parameter int CNT_W       = 9,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         state_o,
    input logic [2*CNT_W-1:0] err_cnt_o,
    input logic [3:0]         status_o,
    input logic               err_req_o,
    input logic               tx_permit_o,
    input logic               tx_bit_o
);
    localparam logic [CNT_W-1:0] PL = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] BL = CNT_W'(BUSOFF_LIM);

    logic [CNT_W-1:0] tec, rec;
    assign tec = err_cnt_o[CNT_W-1:0];
    assign rec = err_cnt_o[2*CNT_W-1:CNT_W];

    AST_TEC_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tec < $past(tec)) |-> (tec == $past(tec) - 1'b1 || tec == '0)); // R1
    AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rec) == '1) |-> (rec >= $past(rec) - 1'b1)); // R2
    AST_PASSIVE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd2) |-> ((state_o == 2'd1) == (tec > PL || rec > PL))); // R4
    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tec > BL) |-> (state_o == 2'd2)); // R5
    AST_BUSOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (tx_bit_o && !err_req_o && !tx_permit_o)); // R6
    AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 2'd2 && state_o == 2'd0) |-> (err_cnt_o == '0)); // R7
    AST_BOFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) != 2'd2 && state_o == 2'd2) |-> status_o[2]); // R11
endmodule

bind can_fault_guard fc_guard_chk #(
    .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state_o(state_o), .err_cnt_o(err_cnt_o),
    .status_o(status_o), .err_req_o(err_req_o),
    .tx_permit_o(tx_permit_o), .tx_bit_o(tx_bit_o)
);

// File: tb/can_fault_guard_bench.sv
`timescale 1ns/1ps
module can_fault_guard_bench;
    localparam int CNT_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
    logic bit_tick_i = 0, bus_bit_i = 1, ack_slot_i = 0, tx_bit_i = 0;
    logic stat_clr_i = 0;
    logic [3:0] irq_mask_i = '0;
    logic [1:0] state_o;
    logic [2*CNT_W-1:0] err_cnt_o;
    logic [3:0] status_o;
    logic irq_o, err_req_o, err_passive_o, tx_permit_o, tx_bit_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    can_fault_guard u_can_fault_guard (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
        .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .bit_tick_i(bit_tick_i),
        .bus_bit_i(bus_bit_i), .ack_slot_i(ack_slot_i), .tx_bit_i(tx_bit_i),
        .stat_clr_i(stat_clr_i), .irq_mask_i(irq_mask_i), .state_o(state_o),
        .err_cnt_o(err_cnt_o), .status_o(status_o), .irq_o(irq_o),
        .err_req_o(err_req_o), .err_passive_o(err_passive_o),
        .tx_permit_o(tx_permit_o), .tx_bit_o(tx_bit_o)
    );

    // {op[1:0], reps[9:0], tec[8:0], rec[8:0], state[1:0]}
    // op: 0 tx_err, 1 rx_err, 2 tx_ok, 3 rx_ok
    localparam logic [31:0] VEC [9] = '{
        {2'd1, 10'd5,   9'd0,   9'd5,   2'd0},
        {2'd3, 10'd7,   9'd0,   9'd0,   2'd0},
        {2'd0, 10'd15,  9'd120, 9'd0,   2'd0},
        {2'd0, 10'd1,   9'd128, 9'd0,   2'd1},
        {2'd2, 10'd1,   9'd127, 9'd0,   2'd0},
        {2'd1, 10'd128, 9'd127, 9'd128, 2'd1},
        {2'd3, 10'd1,   9'd127, 9'd127, 2'd0},
        {2'd0, 10'd17,  9'd263, 9'd127, 2'd2},
        {2'd1, 10'd3,   9'd263, 9'd127, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] ev);
        {tx_err_i, rx_err_i, tx_ok_i, rx_ok_i} = ev;
        @(negedge clk);
        {tx_err_i, rx_err_i, tx_ok_i, rx_ok_i} = 4'b0;
    endtask

    task automatic tick(input logic b, input logic ack);
        bit_tick_i = 1'b1; bus_bit_i = b; ack_slot_i = ack;
        @(negedge clk);
        bit_tick_i = 1'b0; bus_bit_i = 1'b1; ack_slot_i = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        string tags[9] = '{"R2", "R2", "R1", "R4", "R4", "R4", "R4", "R5", "R5"};
        logic [1:0] op; logic [9:0] reps; logic [8:0] et, er; logic [1:0] es;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R3 reset state
        chk("R3 state", 32'(state_o), 0);
        chk("R3 counts", 32'(err_cnt_o), 0);
        chk("R3 status", 32'(status_o), 0);
        chk("R3 permit/req/txbit", {29'b0, tx_permit_o, err_req_o, tx_bit_o}, 32'b100);

        for (int i = 0; i < 9; i++) begin
            {op, reps, et, er, es} = VEC[i];
            for (int k = 0; k < int'(reps); k++) pulse(4'b1000 >> op);
            chk({tags[i], " counts"}, 32'(err_cnt_o), {14'b0, er, et});
            chk({tags[i], " state"}, 32'(state_o), 32'(es));
        end

        // R11 flags from the table walk: active, passive, bus off entered
        chk("R11 sticky", 32'(status_o), 32'b0111);
        // R12 mask
        irq_mask_i = 4'b0100; #1;
        chk("R12 irq on", 32'(irq_o), 1);
        irq_mask_i = 4'b1000; #1;
        chk("R12 irq masked", 32'(irq_o), 0);
        stat_clr_i = 1'b1; idle(); stat_clr_i = 1'b0;
        chk("R11 clear", 32'(status_o), 0);

        // R6 bus off silence
        tx_bit_i = 1'b0; #1;
        chk("R6 txbit forced", 32'(tx_bit_o), 1);
        chk("R6 permit low", 32'(tx_permit_o), 0);
        pulse(4'b1000);
        chk("R6 no request", 32'(err_req_o), 0);
        chk("R5 frozen", 32'(err_cnt_o), {14'b0, 9'd127, 9'd263});

        // R7 recovery: broken run, 127 runs, then 10 bits
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        for (int r = 0; r < 127; r++)
            for (int k = 0; k < 11; k++) tick(1'b1, 1'b0);
        for (int k = 0; k < 10; k++) tick(1'b1, 1'b0);
        chk("R7 not yet", 32'(state_o), 2);
        tick(1'b1, 1'b0);
        chk("R7 recovered", 32'(state_o), 0);
        chk("R7 cleared", 32'(err_cnt_o), 0);
        chk("R11 active flag", 32'(status_o), 32'b0001);
        chk("R6 txbit follows", 32'(tx_bit_o), 0);

        // R9 acknowledge check
        tick(1'b1, 1'b1);
        chk("R9 ack err tec", 32'(err_cnt_o), 8);
        chk("R9 ack flag", 32'(status_o[3]), 1);
        chk("R8 ack request", 32'(err_req_o), 1);
        tick(1'b0, 1'b1);
        chk("R9 dominant ack", 32'(err_cnt_o), 8);
        chk("R8 pulse ends", 32'(err_req_o), 0);

        // R8 request with active flavour
        pulse(4'b0100);
        chk("R8 rx request", {30'b0, err_req_o, err_passive_o}, 32'b10);
        for (int k = 0; k < 16; k++) pulse(4'b1000);
        chk("R1 tec 136", 32'(err_cnt_o), {14'b0, 9'd1, 9'd136});
        pulse(4'b0100);
        chk("R8 passive flavour", {30'b0, err_req_o, err_passive_o}, 32'b11);
        idle();
        chk("R8 one cycle", 32'(err_req_o), 0);

        // R10 suspend
        pulse(4'b0010);
        chk("R10 permit dropped", 32'(tx_permit_o), 0);
        chk("R1 tec dec", 32'(err_cnt_o[8:0]), 135);
        for (int k = 0; k < 7; k++) tick(1'b1, 1'b0);
        chk("R10 after 7", 32'(tx_permit_o), 0);
        tick(1'b0, 1'b0);
        chk("R10 dominant ignored", 32'(tx_permit_o), 0);
        tick(1'b1, 1'b0);
        chk("R10 permit back", 32'(tx_permit_o), 1);

        // R1 error wins over success in one cycle
        pulse(4'b1010);
        chk("R1 err wins", 32'(err_cnt_o[8:0]), 143);

        // R2 saturation
        for (int k = 0; k < 520; k++) pulse(4'b0100);
        chk("R2 saturate", 32'(err_cnt_o[17:9]), 511);
        pulse(4'b0001);
        chk("R2 dec from top", 32'(err_cnt_o[17:9]), 510);

        finish_run();
    end
endmodule